// File: doc/BRIEF.md
# Station Address Register Bank with Clock-Domain Transfer

This block holds a bank of 48-bit station addresses for a network port. Software reaches it from a host register clock. The receive and transmit logic reads it from an unrelated line clock. Each slot has a 16-bit upper word and a 32-bit lower word. Host writes go into a host-side shadow copy under byte-enable control. Host reads always return that shadow copy.

The line-side copy of a slot changes only when the host writes one particular byte lane of the lower word, called the trigger lane. Which lane is the trigger lane depends on an endianness mode input. A trigger write flips a per-slot request toggle. The line domain passes the toggle through two flops, detects the change, and loads the whole 48-bit shadow into its output register in a single cycle. An acknowledge toggle then returns through a two-flop synchronizer. Until that acknowledge arrives the slot reports busy, and the host side drops every write to that slot, so the value being carried across cannot change while it is in flight.

Top module: `staddr_cdc_bank`

## Requirements
- R1: After reset every slot's shadow words read as zero, every line-side address is zero and no slot is busy.
- R2: A host read of slot `rd_slot` returns the lower word when `rd_low`=1. When `rd_low`=0 it returns the upper word in bits [15:0], with bits [31:16] reading zero.
- R3: A write updates only the byte lanes whose `wr_be` bit is set. For the upper word only lanes 0 and 1 (bits [15:0]) exist, and enables 2 and 3 are ignored.
- R4: The trigger lane is lane 3 (bits [31:24] of the lower word) when `big_endian`=0, and lane 0 (bits [7:0]) when `big_endian`=1. A lower-word write with that lane's enable set starts a transfer.
- R5: Writes to the upper word, and lower-word writes without the trigger lane enabled, change only the shadow. The line-side address of the slot stays as it was.
- R6: On a transfer the line-side address of the slot, `line_addr[s*48 +: 48]`, takes `{upper[15:0], lower[31:0]}` in one line clock cycle. It never shows a mixture of old and new bytes.
- R7: `slot_busy[s]` is high from the host cycle after an accepted trigger write until the acknowledge returns. While the slot is busy, any write to it is dropped entirely.
- R8: A transfer on one slot leaves the line-side address of every other slot unchanged. At most one slot becomes busy per host cycle.
- R9: Successive trigger writes to one slot, each issued after the previous busy period ends, all reach the line side in order. The line-side value then holds until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host register clock |
| hrst_n | input | 1 | Host-domain active-low reset |
| big_endian | input | 1 | Endianness mode: selects the trigger lane |
| wr_en | input | 1 | Host write strobe |
| wr_slot | input | 7 | Slot index for the write |
| wr_low | input | 1 | 1 selects the lower 32-bit word, 0 the upper word |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane enables for the write |
| rd_slot | input | 7 | Slot index for the read |
| rd_low | input | 1 | 1 reads the lower word, 0 the upper word |
| rd_data | output | 32 | Read data from the host-side shadow |
| slot_busy | output | 82 | Per-slot transfer-in-flight flags |
| lclk | input | 1 | Line clock |
| lrst_n | input | 1 | Line-domain active-low reset |
| line_addr | output | 3936 | Line-side addresses, slot s at bits [s*48 +: 48] |

## Verification
The line clock runs at a period unrelated to the host clock. Transfers are tried with partial byte enables that leave out the trigger lane, with the trigger lane alone in both endianness modes, and with writes to the upper word only. Together these show whether the trigger decode picks the right lane and whether any other write leaks across. Repeated triggers to one slot with changing values show whether every spaced update arrives. Triggers on several slots in flight at once show whether slots interfere with each other. A write aimed at a busy slot shows whether the shadow is protected while a transfer is in flight.

// File: rtl/staddr_pkg.sv
package staddr_pkg;
    parameter int HI_W   = 16;
    parameter int LO_W   = 32;
    parameter int ADDR_W = HI_W + LO_W;
    parameter int BE_W   = LO_W / 8;
    parameter int HI_BE  = HI_W / 8;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
        logic            req;
    } host_slot_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              seen;
    } line_slot_t;

    function automatic logic [1:0] trig_lane(input logic big_mode);
        return big_mode ? 2'd0 : 2'(BE_W - 1);
    endfunction
endpackage

// File: rtl/staddr_sync2.sv
module staddr_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.sync = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.sync;
endmodule

// File: rtl/staddr_host_slot.sv
module staddr_host_slot
    import staddr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hit_i,
    input  logic            wr_low_i,
    input  logic [LO_W-1:0] wr_data_i,
    input  logic [BE_W-1:0] wr_be_i,
    input  logic            big_endian_i,
    input  logic            ack_async_i,
    output logic [HI_W-1:0] hi_o,
    output logic [LO_W-1:0] lo_o,
    output logic            req_o,
    output logic            busy_o
);
    host_slot_t st_d, st_q;
    logic       ack_s;
    logic       busy;

    staddr_sync2 #(.W(1)) ack_sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(ack_async_i),
        .sync_o (ack_s)
    );

    assign busy = st_q.req ^ ack_s;

    always_comb begin
        st_d = st_q;
        if (wr_hit_i && !busy) begin
            if (wr_low_i) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (wr_be_i[b]) st_d.lo[b*8 +: 8] = wr_data_i[b*8 +: 8];
                end
                if (wr_be_i[trig_lane(big_endian_i)]) st_d.req = ~st_q.req;
            end else begin
                for (int b = 0; b < HI_BE; b++) begin
                    if (wr_be_i[b]) st_d.hi[b*8 +: 8] = wr_data_i[b*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_o   = st_q.hi;
    assign lo_o   = st_q.lo;
    assign req_o  = st_q.req;
    assign busy_o = busy;
endmodule

// File: rtl/staddr_line_slot.sv
module staddr_line_slot
    import staddr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_async_i,
    input  logic [ADDR_W-1:0] shadow_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ack_o
);
    line_slot_t st_d, st_q;
    logic       req_s;

    staddr_sync2 #(.W(1)) req_sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(req_async_i),
        .sync_o (req_s)
    );

    always_comb begin
        st_d = st_q;
        if (req_s != st_q.seen) begin
            st_d.addr = shadow_i;
            st_d.seen = req_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;
    assign ack_o  = st_q.seen;
endmodule

// File: rtl/staddr_cdc_bank.sv
module staddr_cdc_bank
    import staddr_pkg::*;
#(
    parameter int NUM_SLOTS = 82,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                        hclk,
    input  logic                        hrst_n,
    input  logic                        big_endian,
    input  logic                        wr_en,
    input  logic [SLOT_W-1:0]           wr_slot,
    input  logic                        wr_low,
    input  logic [LO_W-1:0]             wr_data,
    input  logic [BE_W-1:0]             wr_be,
    input  logic [SLOT_W-1:0]           rd_slot,
    input  logic                        rd_low,
    output logic [LO_W-1:0]             rd_data,
    output logic [NUM_SLOTS-1:0]        slot_busy,
    input  logic                        lclk,
    input  logic                        lrst_n,
    output logic [NUM_SLOTS*ADDR_W-1:0] line_addr
);
    localparam int FLAT_W = NUM_SLOTS * ADDR_W;

    logic [HI_W-1:0]      hi_arr  [NUM_SLOTS];
    logic [LO_W-1:0]      lo_arr  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] req_vec;
    logic [NUM_SLOTS-1:0] ack_vec;
    logic [FLAT_W-1:0]    shadow_flat;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_slot == SLOT_W'(s));

        staddr_host_slot host_i (
            .clk         (hclk),
            .rst_n       (hrst_n),
            .wr_hit_i    (hit),
            .wr_low_i    (wr_low),
            .wr_data_i   (wr_data),
            .wr_be_i     (wr_be),
            .big_endian_i(big_endian),
            .ack_async_i (ack_vec[s]),
            .hi_o        (hi_arr[s]),
            .lo_o        (lo_arr[s]),
            .req_o       (req_vec[s]),
            .busy_o      (slot_busy[s])
        );

        assign shadow_flat[s*ADDR_W +: ADDR_W] = {hi_arr[s], lo_arr[s]};

        staddr_line_slot line_i (
            .clk        (lclk),
            .rst_n      (lrst_n),
            .req_async_i(req_vec[s]),
            .shadow_i   (shadow_flat[s*ADDR_W +: ADDR_W]),
            .addr_o     (line_addr[s*ADDR_W +: ADDR_W]),
            .ack_o      (ack_vec[s])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (rd_slot == SLOT_W'(s)) begin
                rd_data = rd_low ? lo_arr[s] : {{(LO_W-HI_W){1'b0}}, hi_arr[s]};
            end
        end
    end
endmodule

// File: rtl/staddr_cdc_checker.sv
module staddr_cdc_checker
    import staddr_pkg::*;
#(
    parameter int NUM_SLOTS = 82,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input logic                        hclk,
    input logic                        hrst_n,
    input logic                        lclk,
    input logic                        lrst_n,
    input logic                        big_endian,
    input logic                        wr_en,
    input logic [SLOT_W-1:0]           wr_slot,
    input logic                        wr_low,
    input logic [BE_W-1:0]             wr_be,
    input logic [NUM_SLOTS-1:0]        slot_busy,
    input logic [NUM_SLOTS*ADDR_W-1:0] shadow_flat,
    input logic [NUM_SLOTS*ADDR_W-1:0] line_addr
);
    logic trig_w;
    assign trig_w = wr_en && wr_low && wr_be[trig_lane(big_endian)];

    AST_RESET_IDLE: assert property (@(posedge hclk) disable iff (!hrst_n)
        $rose(hrst_n) |-> (slot_busy == '0)); // R1

    AST_LINE_RESET_ZERO: assert property (@(posedge lclk) disable iff (!lrst_n)
        $rose(lrst_n) |-> (line_addr == '0)); // R1

    AST_NONTRIGGER_NO_BUSY: assert property (@(posedge hclk) disable iff (!hrst_n)
        (wr_en && !trig_w && !slot_busy[wr_slot]) |=> !slot_busy[$past(wr_slot)]); // R5

    AST_BUSY_AFTER_TRIGGER: assert property (@(posedge hclk) disable iff (!hrst_n)
        (trig_w && !slot_busy[wr_slot]) |=> slot_busy[$past(wr_slot)]); // R7

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge hclk) disable iff (!hrst_n)
        (wr_en && slot_busy[wr_slot]) |=> $stable(shadow_flat)); // R7

    AST_SINGLE_NEW_BUSY: assert property (@(posedge hclk) disable iff (!hrst_n)
        $countones(slot_busy) <= $countones($past(slot_busy)) + 1); // R8

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
        AST_LINE_WHOLE_VALUE: assert property (@(posedge lclk) disable iff (!lrst_n || !hrst_n)
            (line_addr[s*ADDR_W +: ADDR_W] != $past(line_addr[s*ADDR_W +: ADDR_W]))
            |-> (line_addr[s*ADDR_W +: ADDR_W] == shadow_flat[s*ADDR_W +: ADDR_W])); // R6
    end
endmodule

bind staddr_cdc_bank staddr_cdc_checker #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) chk_i (
    .hclk       (hclk),
    .hrst_n     (hrst_n),
    .lclk       (lclk),
    .lrst_n     (lrst_n),
    .big_endian (big_endian),
    .wr_en      (wr_en),
    .wr_slot    (wr_slot),
    .wr_low     (wr_low),
    .wr_be      (wr_be),
    .slot_busy  (slot_busy),
    .shadow_flat(shadow_flat),
    .line_addr  (line_addr)
);

// File: tb/staddr_cdc_bank_tb_top.sv
`timescale 1ns/10ps
module staddr_cdc_bank_tb_top;
    localparam int NS = 82;
    localparam int SW = 7;
    localparam int AW = 48;

    typedef struct {
        int          slot;
        logic [47:0] val;
    } exp_t;

    logic hclk = 0, lclk = 0, hrst_n = 0, lrst_n = 0;
    logic big_endian = 0, wr_en = 0, wr_low = 0, rd_low = 0;
    logic [SW-1:0] wr_slot = '0, rd_slot = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] rd_data;
    logic [NS-1:0] slot_busy;
    logic [NS*AW-1:0] line_addr;

    int n_checks = 0, n_fail = 0;
    exp_t exp_q[$];
    logic [15:0] m_hi [NS];
    logic [31:0] m_lo [NS];
    logic [47:0] m_line [NS];

    always #5    hclk = ~hclk;
    always #6.85 lclk = ~lclk;

    staddr_cdc_bank dut_i (
        .hclk(hclk), .hrst_n(hrst_n), .big_endian(big_endian), .wr_en(wr_en),
        .wr_slot(wr_slot), .wr_low(wr_low), .wr_data(wr_data), .wr_be(wr_be),
        .rd_slot(rd_slot), .rd_low(rd_low), .rd_data(rd_data), .slot_busy(slot_busy),
        .lclk(lclk), .lrst_n(lrst_n), .line_addr(line_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Driver: performs a host write, updates the model, queues expected transfers
    task automatic hwrite(input int s, input logic low, input logic [31:0] d, input logic [3:0] be);
        logic accepted;
        @(negedge hclk);
        wr_en = 1; wr_slot = SW'(s); wr_low = low; wr_data = d; wr_be = be;
        accepted = !slot_busy[s];
        @(posedge hclk);
        if (accepted) begin
            if (low) begin
                for (int b = 0; b < 4; b++) if (be[b]) m_lo[s][b*8 +: 8] = d[b*8 +: 8];
                if (be[big_endian ? 0 : 3]) begin
                    m_line[s] = {m_hi[s], m_lo[s]};
                    exp_q.push_back('{slot: s, val: {m_hi[s], m_lo[s]}});
                end
            end else begin
                for (int b = 0; b < 2; b++) if (be[b]) m_hi[s][b*8 +: 8] = d[b*8 +: 8];
            end
        end
        @(negedge hclk);
        wr_en = 0;
    endtask

    task automatic hread(input int s, input logic low, output logic [31:0] d);
        rd_slot = SW'(s); rd_low = low;
        #1;
        d = rd_data;
    endtask

    task automatic wait_idle(input int s);
        int guard = 0;
        @(negedge hclk);
        while (slot_busy[s] && guard < 200) begin
            @(negedge hclk);
            guard++;
        end
        repeat (2) @(negedge lclk);
        @(negedge hclk);
    endtask

    // Monitor: pops expected transfers as line-side values change
    initial begin
        logic [NS*AW-1:0] prev;
        prev = '0;
        forever begin
            @(negedge lclk);
            if (lrst_n) begin
                for (int s = 0; s < NS; s++) begin
                    if (line_addr[s*AW +: AW] != prev[s*AW +: AW]) begin
                        int idx;
                        idx = -1;
                        foreach (exp_q[i]) if (idx < 0 && exp_q[i].slot == s) idx = i;
                        if (idx < 0) begin
                            chk("R8 unexpected line change", 64'(line_addr[s*AW +: AW]), 64'(prev[s*AW +: AW]));
                        end else begin
                            chk("R6 transferred value", 64'(line_addr[s*AW +: AW]), 64'(exp_q[idx].val));
                            exp_q.delete(idx);
                        end
                    end
                end
            end
            prev = line_addr;
        end
    end

    initial begin
        repeat (150000) @(posedge hclk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        for (int s = 0; s < NS; s++) begin m_hi[s] = '0; m_lo[s] = '0; m_line[s] = '0; end
        repeat (4) @(negedge hclk);
        hrst_n = 1;
        @(negedge lclk);
        lrst_n = 1;
        repeat (3) @(negedge hclk);

        // R1 reset state
        chk("R1 busy after reset", 64'(slot_busy), 64'(0));
        chk("R1 line after reset", 64'(line_addr[3*AW +: AW]), 64'(0));
        chk("R1 line all zero", 64'(|line_addr), 64'(0));
        hread(3, 1, d); chk("R1 low reads zero", 64'(d), 64'(0));
        hread(81, 0, d); chk("R1 high reads zero", 64'(d), 64'(0));

        // R2/R3 upper word write, lanes 2..3 ignored
        hwrite(3, 0, 32'h7777ABCD, 4'b1111);
        hread(3, 0, d); chk("R2 upper word readback", 64'(d), 64'h0000ABCD);
        repeat (12) @(negedge lclk);
        chk("R5 upper write leaves line", 64'(line_addr[3*AW +: AW]), 64'(m_line[3]));

        // R3/R5 partial lower write without trigger lane
        hwrite(3, 1, 32'h44332211, 4'b0111);
        hread(3, 1, d); chk("R3 byte enables lower", 64'(d), 64'h00332211);
        hwrite(3, 1, 32'h99990000, 4'b0100);
        hread(3, 1, d); chk("R3 single lane", 64'(d), 64'h00992211);
        repeat (12) @(negedge lclk);
        chk("R5 non-trigger lanes leave line", 64'(line_addr[3*AW +: AW]), 64'(0));
        chk("R5 no busy", 64'(slot_busy[3]), 64'(0));

        // R4/R7 trigger lane 3, busy, dropped write
        hwrite(3, 1, 32'h88000000, 4'b1000);
        chk("R7 busy after trigger", 64'(slot_busy[3]), 64'(1));
        hwrite(3, 0, 32'h0000FFFF, 4'b0011);
        hread(3, 0, d); chk("R7 write to busy slot dropped", 64'(d), 64'h0000ABCD);
        wait_idle(3);
        chk("R7 busy clears", 64'(slot_busy[3]), 64'(0));
        chk("R4 little-endian trigger", 64'(line_addr[3*AW +: AW]), 64'h0000ABCD88992211);

        // R4 big-endian: lane 3 no longer triggers, lane 0 does
        big_endian = 1;
        hwrite(81, 0, 32'h00001234, 4'b0011);
        hwrite(81, 1, 32'hCAFE0000, 4'b1100);
        repeat (12) @(negedge lclk);
        chk("R4 lane 3 idle in big-endian", 64'(line_addr[81*AW +: AW]), 64'(0));
        hwrite(81, 1, 32'h000000EE, 4'b0001);
        wait_idle(81);
        chk("R4 big-endian trigger lane 0", 64'(line_addr[81*AW +: AW]), 64'h1234CAFE00EE);
        big_endian = 0;

        // R8 several slots in flight, others untouched
        hwrite(0, 0, 32'h00000102, 4'b0011);
        hwrite(0, 1, 32'h03040506, 4'b1111);
        hwrite(40, 1, 32'hA1B2C3D4, 4'b1111);
        hwrite(41, 1, 32'h5A5A5A5A, 4'b1111);
        wait_idle(0); wait_idle(40); wait_idle(41);
        chk("R8 slot 0", 64'(line_addr[0*AW +: AW]), 64'h010203040506);
        chk("R8 slot 40", 64'(line_addr[40*AW +: AW]), 64'hA1B2C3D4);
        chk("R8 slot 41", 64'(line_addr[41*AW +: AW]), 64'h5A5A5A5A);
        chk("R8 slot 3 untouched", 64'(line_addr[3*AW +: AW]), 64'(m_line[3]));
        chk("R8 slot 81 untouched", 64'(line_addr[81*AW +: AW]), 64'(m_line[81]));

        // R9 spaced repeated triggers on one slot
        for (int k = 0; k < 6; k++) begin
            hwrite(10, 0, 32'(16'h1000 + k), 4'b0011);
            hwrite(10, 1, 32'h11223300 + 32'(k), 4'b1111);
            wait_idle(10);
            chk("R9 repeated trigger", 64'(line_addr[10*AW +: AW]), 64'(m_line[10]));
        end
        repeat (20) @(negedge lclk);
        chk("R9 line holds", 64'(line_addr[10*AW +: AW]), 64'h100511223305);
        chk("R9 all transfers seen", 64'(exp_q.size()), 64'(0));
        finish_run();
    end
endmodule